// File: doc/BRIEF.md
# Serial EEPROM Boot Image Loader

This block brings the program memory up after reset. When the programming-mode pin is low, it steers a two-wire byte master through that master's command port and copies the whole program image from an external serial EEPROM into the on-chip program SRAM. The CPU is held in reset until the copy is finished.

The transfer starts with a write frame that carries the device byte and the two memory-address bytes but no data. This frame only loads the EEPROM's internal address pointer. A repeated start follows, then the device byte with the read flag set, and then a single sequential read over the whole image. Every received byte goes to SRAM at the address held in an internal counter, which then advances. The counter also decides whether the byte is acknowledged: every byte is acknowledged except the one read while the counter sits on the last SRAM location. That last read is followed by a stop. When the stop has completed, a loaded flag rises and the CPU reset hold is released.

Each master command is a one-cycle strobe. The master answers by raising busy and dropping it when the bus operation is over. The sequencer waits until it has seen busy high and then low before it takes the next step.

Top module: `boot_loader_seq`

## Requirements
- R1: After reset, while `prog_mode_i` is high, no command is strobed, `load_done_o` stays 0, `cpu_hold_o` stays 1 and no SRAM write happens.
- R2: Once `prog_mode_i` is low, the first command is start (code 9). It is followed by a transmit (code 3) of the write device byte {4'b1010, DEV_SEL, 1'b0}.
- R3: Next come two transmits of START_ADDR: high byte first, then low byte, with no data byte. Then another start (code 9) and a transmit of the read device byte {4'b1010, DEV_SEL, 1'b1}.
- R4: Every image byte except the last is received with the acknowledging receive command (code 2).
- R5: The byte read while the address counter is all ones is received with the non-acknowledging receive command (code 6). It is directly followed by a stop (code 5).
- R6: Each command strobe lasts one cycle. It is never given while busy is high. The next command waits until busy has been seen high and then low.
- R7: When busy falls after a receive, one single-cycle SRAM write is issued. Its address is the counter value (counting from 0) and its data is the received byte. There are 2^ADDR_W writes in total, at consecutive addresses.
- R8: `load_done_o` rises only after the stop has completed and then stays high. `cpu_hold_o` is high until that moment and low afterwards.
- R9: After `load_done_o` is set, no further commands or SRAM writes occur, whatever `prog_mode_i` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_mode_i | input | 1 | Programming-mode pin; the loader runs only while it is low |
| mst_cmd_o | output | 4 | Command code for the byte master |
| mst_cmd_we_o | output | 1 | One-cycle command strobe |
| mst_txd_o | output | 8 | Byte to transmit, valid with a transmit command |
| mst_busy_i | input | 1 | Master busy flag |
| mst_rxd_i | input | 8 | Byte received by the master |
| sram_we_o | output | 1 | SRAM write enable pulse |
| sram_addr_o | output | 13 | SRAM write address (ADDR_W) |
| sram_wdata_o | output | 8 | SRAM write data |
| load_done_o | output | 1 | Image fully loaded |
| cpu_hold_o | output | 1 | Holds the CPU in reset until the load is done |

## Verification
The hardest point to reach is the very end of the image. The switch from acknowledging to non-acknowledging receive, the stop that follows, and the release of the CPU hold happen only after thousands of correct reads, each with its own busy handshake. The bench therefore models the byte master and the EEPROM in full. The model answers every command with a multi-cycle busy pulse, tracks its own address pointer from the dummy write, and serves a computed data pattern. The run then goes through all 8192 reads, and the bench compares each SRAM write and the final command pair against values it computes itself.

// File: rtl/boot_ld_pkg.sv
package boot_ld_pkg;

  typedef enum logic [3:0] {
    CMD_RX_ACK  = 4'd2,
    CMD_TX      = 4'd3,
    CMD_STOP    = 4'd5,
    CMD_RX_NACK = 4'd6,
    CMD_START   = 4'd9
  } bus_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START_W,
    ST_DEV_W,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_START_R,
    ST_DEV_R,
    ST_READ,
    ST_STOP,
    ST_DONE
  } step_e;

  localparam logic [3:0] DEV_FAMILY = 4'b1010;

endpackage

// File: rtl/boot_addr_ctr.sv
module boot_addr_ctr #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  output logic [W-1:0] count_o,
  output logic         last_o
);
  always_ff @(posedge clk) begin
    if (rst)        count_o <= '0;
    else if (inc_i) count_o <= count_o + 1'b1;
  end

  assign last_o = &count_o;
endmodule

// File: rtl/boot_busy_track.sv
module boot_busy_track (
  input  logic clk,
  input  logic rst,
  input  logic issue_i,
  input  logic busy_i,
  output logic done_o
);
  logic waiting_q, seen_q;

  assign done_o = waiting_q & seen_q & ~busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting_q <= 1'b0;
      seen_q    <= 1'b0;
    end else if (issue_i) begin
      waiting_q <= 1'b1;
      seen_q    <= 1'b0;
    end else if (done_o) begin
      waiting_q <= 1'b0;
      seen_q    <= 1'b0;
    end else if (waiting_q && busy_i) begin
      seen_q    <= 1'b1;
    end
  end
endmodule

// File: rtl/boot_step_fsm.sv
module boot_step_fsm
  import boot_ld_pkg::*;
#(
  parameter int          ADDR_W     = 13,
  parameter logic [2:0]  DEV_SEL    = 3'b000,
  parameter logic [15:0] START_ADDR = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_mode_i,
  input  logic              xfer_done_i,
  input  logic              ctr_last_i,
  input  logic [ADDR_W-1:0] ctr_val_i,
  input  logic [7:0]        rxd_i,
  output logic [3:0]        cmd_o,
  output logic              cmd_we_o,
  output logic [7:0]        txd_o,
  output logic              ctr_inc_o,
  output logic              sram_we_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [7:0]        sram_wdata_o,
  output logic              load_done_o,
  output logic              cpu_hold_o
);
  localparam logic [7:0] DEV_WR = {DEV_FAMILY, DEV_SEL, 1'b0};
  localparam logic [7:0] DEV_RD = {DEV_FAMILY, DEV_SEL, 1'b1};

  step_e    step_q, next_step;
  logic     issue_q;
  bus_cmd_e step_cmd;
  logic [7:0] step_byte;

  always_comb begin
    step_cmd  = CMD_START;
    step_byte = 8'h00;
    next_step = step_q;
    case (step_q)
      ST_START_W: begin step_cmd = CMD_START; next_step = ST_DEV_W; end
      ST_DEV_W:   begin step_cmd = CMD_TX; step_byte = DEV_WR; next_step = ST_ADDR_HI; end
      ST_ADDR_HI: begin step_cmd = CMD_TX; step_byte = START_ADDR[15:8]; next_step = ST_ADDR_LO; end
      ST_ADDR_LO: begin step_cmd = CMD_TX; step_byte = START_ADDR[7:0]; next_step = ST_START_R; end
      ST_START_R: begin step_cmd = CMD_START; next_step = ST_DEV_R; end
      ST_DEV_R:   begin step_cmd = CMD_TX; step_byte = DEV_RD; next_step = ST_READ; end
      ST_READ: begin
        step_cmd  = ctr_last_i ? CMD_RX_NACK : CMD_RX_ACK;
        next_step = ctr_last_i ? ST_STOP : ST_READ;
      end
      ST_STOP:    begin step_cmd = CMD_STOP; next_step = ST_DONE; end
      default:    begin step_cmd = CMD_START; next_step = step_q; end
    endcase
  end

  assign ctr_inc_o = (step_q == ST_READ) && !issue_q && xfer_done_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q       <= ST_IDLE;
      issue_q      <= 1'b1;
      cmd_o        <= CMD_START;
      cmd_we_o     <= 1'b0;
      txd_o        <= 8'h00;
      sram_we_o    <= 1'b0;
      sram_addr_o  <= '0;
      sram_wdata_o <= 8'h00;
      load_done_o  <= 1'b0;
      cpu_hold_o   <= 1'b1;
    end else begin
      cmd_we_o  <= 1'b0;
      sram_we_o <= 1'b0;
      case (step_q)
        ST_IDLE: begin
          issue_q <= 1'b1;
          if (!prog_mode_i) step_q <= ST_START_W;
        end
        ST_DONE: ;
        default: begin
          if (issue_q) begin
            cmd_we_o <= 1'b1;
            cmd_o    <= step_cmd;
            txd_o    <= step_byte;
            issue_q  <= 1'b0;
          end else if (xfer_done_i) begin
            issue_q <= 1'b1;
            step_q  <= next_step;
            if (step_q == ST_READ) begin
              sram_we_o    <= 1'b1;
              sram_addr_o  <= ctr_val_i;
              sram_wdata_o <= rxd_i;
            end
            if (step_q == ST_STOP) begin
              load_done_o <= 1'b1;
              cpu_hold_o  <= 1'b0;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/boot_loader_seq.sv
module boot_loader_seq #(
  parameter int          ADDR_W     = 13,
  parameter logic [2:0]  DEV_SEL    = 3'b000,
  parameter logic [15:0] START_ADDR = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_mode_i,
  output logic [3:0]        mst_cmd_o,
  output logic              mst_cmd_we_o,
  output logic [7:0]        mst_txd_o,
  input  logic              mst_busy_i,
  input  logic [7:0]        mst_rxd_i,
  output logic              sram_we_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [7:0]        sram_wdata_o,
  output logic              load_done_o,
  output logic              cpu_hold_o
);
  logic              xfer_done, ctr_inc, ctr_last;
  logic [ADDR_W-1:0] ctr_val;

  boot_busy_track u_track (
    .clk     (clk),
    .rst     (rst),
    .issue_i (mst_cmd_we_o),
    .busy_i  (mst_busy_i),
    .done_o  (xfer_done)
  );

  boot_addr_ctr #(.W(ADDR_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .inc_i   (ctr_inc),
    .count_o (ctr_val),
    .last_o  (ctr_last)
  );

  boot_step_fsm #(
    .ADDR_W     (ADDR_W),
    .DEV_SEL    (DEV_SEL),
    .START_ADDR (START_ADDR)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .prog_mode_i  (prog_mode_i),
    .xfer_done_i  (xfer_done),
    .ctr_last_i   (ctr_last),
    .ctr_val_i    (ctr_val),
    .rxd_i        (mst_rxd_i),
    .cmd_o        (mst_cmd_o),
    .cmd_we_o     (mst_cmd_we_o),
    .txd_o        (mst_txd_o),
    .ctr_inc_o    (ctr_inc),
    .sram_we_o    (sram_we_o),
    .sram_addr_o  (sram_addr_o),
    .sram_wdata_o (sram_wdata_o),
    .load_done_o  (load_done_o),
    .cpu_hold_o   (cpu_hold_o)
  );
endmodule

// File: rtl/boot_loader_seq_chk.sv
module boot_loader_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] cmd,
  input logic       cmd_we,
  input logic       busy,
  input logic       sram_we,
  input logic       load_done,
  input logic       cpu_hold
);
  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_we |=> !cmd_we);

  assert_no_cmd_busy_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_we |-> !busy);

  assert_code_legal_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_we |-> (cmd == 4'd2 || cmd == 4'd3 || cmd == 4'd5 || cmd == 4'd6 || cmd == 4'd9));

  assert_we_single_R7: assert property (@(posedge clk) disable iff (rst)
    sram_we |=> !sram_we);

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    load_done |=> load_done);

  assert_hold_release_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(load_done) |-> $fell(cpu_hold));

  assert_quiet_after_R9: assert property (@(posedge clk) disable iff (rst)
    load_done |-> (!cmd_we && !sram_we));
endmodule

bind boot_loader_seq boot_loader_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd       (mst_cmd_o),
  .cmd_we    (mst_cmd_we_o),
  .busy      (mst_busy_i),
  .sram_we   (sram_we_o),
  .load_done (load_done_o),
  .cpu_hold  (cpu_hold_o)
);

// File: tb/boot_loader_seq_tb.sv
`timescale 1ns/1ps
module boot_loader_seq_tb;
  localparam int          AW    = 13;
  localparam int          NBYTE = 1 << AW;
  localparam logic [2:0]  SEL   = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog = 1'b1;
  logic [3:0] cmd;
  logic cmd_we;
  logic [7:0] txd;
  logic busy = 1'b0;
  logic [7:0] rxd = 8'h00;
  logic sram_we;
  logic [AW-1:0] sram_addr;
  logic [7:0] sram_wdata;
  logic load_done, cpu_hold;

  always #2.5 clk = ~clk;

  boot_loader_seq #(.ADDR_W(AW), .DEV_SEL(SEL), .START_ADDR(16'h0000)) u_dut (
    .clk(clk), .rst(rst), .prog_mode_i(prog),
    .mst_cmd_o(cmd), .mst_cmd_we_o(cmd_we), .mst_txd_o(txd),
    .mst_busy_i(busy), .mst_rxd_i(rxd),
    .sram_we_o(sram_we), .sram_addr_o(sram_addr), .sram_wdata_o(sram_wdata),
    .load_done_o(load_done), .cpu_hold_o(cpu_hold)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], 3'b000} ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Byte master and EEPROM model
  int cmd_cnt = 0, busy_cnt = 0, tx_idx = 0;
  int n_ack = 0, n_nack = 0, n_stop = 0, stop_after_nack = 0;
  int cmd_after_done = 0, cmd_while_busy = 0;
  logic [3:0] last_cmd = 4'd0;
  logic [7:0] hi_q = 8'h00;
  logic [15:0] ee_ptr = 16'h0000;
  logic [3:0] hdr_cmd [0:7];
  logic [7:0] hdr_tx  [0:7];

  always @(posedge clk) begin
    if (cmd_we) begin
      if (cmd_cnt < 8) begin hdr_cmd[cmd_cnt] <= cmd; hdr_tx[cmd_cnt] <= txd; end
      cmd_cnt <= cmd_cnt + 1;
      if (busy) cmd_while_busy <= cmd_while_busy + 1;
      if (load_done) cmd_after_done <= cmd_after_done + 1;
      if (cmd == 4'd2) n_ack <= n_ack + 1;
      if (cmd == 4'd6) n_nack <= n_nack + 1;
      if (cmd == 4'd5) begin
        n_stop <= n_stop + 1;
        if (last_cmd == 4'd6) stop_after_nack <= stop_after_nack + 1;
      end
      if (cmd == 4'd9) tx_idx <= 0;
      if (cmd == 4'd3) begin
        tx_idx <= tx_idx + 1;
        if (tx_idx == 1) hi_q <= txd;
        if (tx_idx == 2) ee_ptr <= {hi_q, txd};
      end
      last_cmd <= cmd;
      busy     <= 1'b1;
      busy_cnt <= 3;
    end else if (busy_cnt > 0) begin
      busy_cnt <= busy_cnt - 1;
      if (busy_cnt == 1) begin
        busy <= 1'b0;
        if (last_cmd == 4'd2 || last_cmd == 4'd6) begin
          rxd    <= pat(ee_ptr);
          ee_ptr <= ee_ptr + 16'd1;
        end
      end
    end
  end

  // SRAM monitor
  int wr_cnt = 0, wr_bad = 0, last_wr_nack = 0, we_double = 0, early_done = 0;
  logic prev_we = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (sram_we) begin
        if (sram_addr != wr_cnt[AW-1:0] || sram_wdata != pat(wr_cnt[15:0])) begin
          if (wr_bad == 0)
            $display("FAIL R7 write %0d addr=%0d data=%0h expected addr=%0d data=%0h",
                     wr_cnt, sram_addr, sram_wdata, wr_cnt, pat(wr_cnt[15:0]));
          wr_bad++;
        end
        if (wr_cnt == NBYTE - 1 && last_cmd == 4'd6) last_wr_nack = 1;
        wr_cnt++;
      end
      if (sram_we && prev_we) we_double++;
      if (load_done && n_stop == 0) early_done++;
      prev_we = sram_we;
    end
  end

  task automatic t_reset;
    rst = 1'b1; prog = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!cmd_we && !sram_we, "R1 reset strobes", cmd_we + sram_we, 0);
    check(!load_done && cpu_hold, "R8 reset flags", {load_done, cpu_hold}, 1);
  endtask

  task automatic t_prog_hold;
    repeat (40) @(negedge clk);
    check(cmd_cnt == 0, "R1 no command while programming", cmd_cnt, 0);
    check(wr_cnt == 0, "R1 no write while programming", wr_cnt, 0);
    check(!load_done && cpu_hold, "R1 held while programming", {load_done, cpu_hold}, 1);
  endtask

  task automatic t_full_load;
    @(posedge clk); #1 prog = 1'b0;
    while (!load_done) @(negedge clk);
    check(hdr_cmd[0] == 4'd9, "R2 first start", hdr_cmd[0], 9);
    check(hdr_cmd[1] == 4'd3 && hdr_tx[1] == {4'b1010, SEL, 1'b0}, "R2 write device byte", hdr_tx[1], {4'b1010, SEL, 1'b0});
    check(hdr_cmd[2] == 4'd3 && hdr_tx[2] == 8'h00, "R3 high address", hdr_tx[2], 0);
    check(hdr_cmd[3] == 4'd3 && hdr_tx[3] == 8'h00, "R3 low address", hdr_tx[3], 0);
    check(hdr_cmd[4] == 4'd9, "R3 repeated start", hdr_cmd[4], 9);
    check(hdr_cmd[5] == 4'd3 && hdr_tx[5] == {4'b1010, SEL, 1'b1}, "R3 read device byte", hdr_tx[5], {4'b1010, SEL, 1'b1});
    check(hdr_cmd[6] == 4'd2, "R4 first receive acks", hdr_cmd[6], 2);
    check(n_ack == NBYTE - 1, "R4 ack receive count", n_ack, NBYTE - 1);
    check(n_nack == 1, "R5 nack receive count", n_nack, 1);
    check(stop_after_nack == 1 && n_stop == 1, "R5 stop after nack", stop_after_nack, 1);
    check(last_wr_nack == 1, "R5 last byte via nack", last_wr_nack, 1);
    check(cmd_while_busy == 0, "R6 command while busy", cmd_while_busy, 0);
    check(cmd_cnt == NBYTE + 7, "R6 total commands", cmd_cnt, NBYTE + 7);
    check(wr_cnt == NBYTE, "R7 write count", wr_cnt, NBYTE);
    check(wr_bad == 0, "R7 write address and data", wr_bad, 0);
    check(we_double == 0, "R7 single-cycle write", we_double, 0);
    check(early_done == 0, "R8 done not before stop", early_done, 0);
    check(!cpu_hold, "R8 hold released", cpu_hold, 0);
  endtask

  task automatic t_after_done;
    #1 prog = 1'b1;
    repeat (20) @(negedge clk);
    #1 prog = 1'b0;
    repeat (30) @(negedge clk);
    check(cmd_after_done == 0 && cmd_cnt == NBYTE + 7, "R9 no commands after done", cmd_cnt, NBYTE + 7);
    check(wr_cnt == NBYTE, "R9 no writes after done", wr_cnt, NBYTE);
    check(load_done && !cpu_hold, "R8 done sticky", {load_done, cpu_hold}, 2);
  endtask

  initial begin
    t_reset();
    t_prog_hold();
    t_full_load();
    t_after_done();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=load complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule